// File: doc/BRIEF.md
# Radio Capture Command Register Unit

This unit sits on a 32-bit register write bus and turns writes into streaming requests for a sample producer. Software first stages the packet length and a 64-bit total sample count. The count is written as two 32-bit halves. Software then writes a command word. The unit answers with a single-cycle start or stop request. Together with the start request it presents the launched settings: the continuous/finite flag, the 64-bit count and the packet size in words.

The radio window begins at `BASE_ADDR` (0x1000). Each channel owns a 0x80-byte slot. Only channel 0 is acted on. Writes that land in other slots raise a warning pulse and change nothing. A timed-command bit in the command word is dropped, so the command runs immediately and a warning pulse is raised. Unknown command codes raise an error pulse and start nothing.

A combinational read port returns a width information word. It also returns a scratch word used by software for loopback checks.

Top module: `radio_cmd_regs`

## Requirements
- R1: The write window is BASE_ADDR (0x1000) up to BASE_ADDR + 2*0x80. Channel = (addr-0x1000)/0x80 and register offset = (addr-0x1000) mod 0x80. Writes outside the window have no effect on any output and raise no warning.
- R2: A channel-0 write at offset 0x28 stages the packet length. The staged value appears on `pkt_words` only together with the next start pulse.
- R3: Offset 0x18 stages bits [31:0] of the total count and offset 0x1C stages bits [63:32]. Each write replaces only its own half and keeps the other half.
- R4: A channel-0 write at offset 0x14 is a command; its code is bits [30:0]. Code 0 gives a stop pulse and leaves the launched settings unchanged. Code 1 (finite) gives a start pulse with `cont_flag`=0. Code 2 (continuous) gives a start pulse with `cont_flag`=1. Each start loads `total_count` and `pkt_words` from the staged values.
- R5: When command bit 31 is set, it is ignored for decoding, the command executes at once, and `timed_warn` pulses in the same cycle as the result.
- R6: Any command code other than 0, 1 or 2 pulses `cmd_err`. It produces neither start nor stop and leaves the launched settings unchanged.
- R7: A write to any offset other than 0x40 in a channel slot above 0 pulses `chan_warn`. It changes neither the staged nor the launched settings.
- R8: Reading 0x1004 returns SAMPLES_PER_CYCLE in [15:0] and SAMPLE_WIDTH in [31:16].
- R9: A write at slot offset 0x40 (0x1040 or 0x10C0) stores a scratch word. The scratch word reads back at offset 0x40 or 0x3C of any slot. All other reads return 0.
- R10: Each start pulse resets the staged count and packet length to 0. A later start that is not reprogrammed launches zeros.
- R11: `start_pulse`, `stop_pulse`, `cmd_err`, `timed_warn` and `chan_warn` are high for exactly the one cycle after the write that causes them.
- R12: After reset, all pulses are 0, `cont_flag`=1, `total_count`=0, `pkt_words`=0 and the scratch word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data |
| start_pulse | output | 1 | Stream start request |
| stop_pulse | output | 1 | Stream stop request |
| cont_flag | output | 1 | Launched stream is continuous |
| total_count | output | 2*DATA_W | Launched total sample count |
| pkt_words | output | DATA_W | Launched packet size in words |
| cmd_err | output | 1 | Unknown command code |
| timed_warn | output | 1 | Timed flag was stripped |
| chan_warn | output | 1 | Write to unsupported channel |

## Verification
The command path is driven with every code, each with and without the timed bit, and with two unknown codes. This separates the start, stop and error outcomes, and shows that the timed bit changes only the warning. Count halves are written in mixed order, including a second low write after the high write. This exposes any half that clobbers the other. Back-to-back starts without reprogramming show whether staged values are cleared. Channel-1 writes, including a command, are placed between the others to show they leave no trace. An out-of-window write shows it is fully ignored. The read path is probed at the width word, at both scratch aliases in both slots, and at an unmapped offset.

// File: rtl/radio_cmd_pkg.sv
// Shared constants for the radio capture command register unit.
// Assumes slot offsets fit in 7 bits (0x80-byte channel slots).
package radio_cmd_pkg;
    localparam int unsigned OFF_CMD     = 'h14;
    localparam int unsigned OFF_CNT_LO  = 'h18;
    localparam int unsigned OFF_CNT_HI  = 'h1C;
    localparam int unsigned OFF_PKT     = 'h28;
    localparam int unsigned OFF_SCR_ALT = 'h3C;
    localparam int unsigned OFF_SCRATCH = 'h40;
    localparam int unsigned OFF_WIDTH   = 'h04;

    localparam int unsigned CODE_STOP   = 0;
    localparam int unsigned CODE_FINITE = 1;
    localparam int unsigned CODE_CONT   = 2;
endpackage

// File: rtl/radio_slot_decode.sv
// Splits a byte address into window hit, channel slot and slot offset.
// Assumes BASE_ADDR is aligned to SLOT_BYTES and SLOT_BYTES is a power of two.
module radio_slot_decode #(
    parameter int ADDR_W     = 20,
    parameter int BASE_ADDR  = 'h1000,
    parameter int SLOT_BYTES = 128,
    parameter int NUM_SLOTS  = 2,
    localparam int OFF_W     = $clog2(SLOT_BYTES),
    localparam int CHAN_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CHAN_W-1:0] chan,
    output logic [OFF_W-1:0]  off
);
    logic [ADDR_W-1:0] rel;

    // Relative address, window test and field split.
    always_comb begin
        rel  = addr - ADDR_W'(BASE_ADDR);
        hit  = (addr >= ADDR_W'(BASE_ADDR)) &&
               (rel < ADDR_W'(NUM_SLOTS * SLOT_BYTES));
        off  = rel[OFF_W-1:0];
        chan = rel[OFF_W +: CHAN_W];
    end
endmodule

// File: rtl/radio_stream_cfg.sv
// Stages channel-0 stream settings and decodes command writes into
// start/stop pulses with launched settings. Assumes wr_stb is already
// qualified to channel 0 of the radio window.
module radio_stream_cfg
    import radio_cmd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFF_W  = 7,
    localparam int CNT_W = 2 * DATA_W,
    localparam int CODE_W = DATA_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    output logic              start_pulse,
    output logic              stop_pulse,
    output logic              cont_flag,
    output logic [CNT_W-1:0]  total_count,
    output logic [DATA_W-1:0] pkt_words,
    output logic              cmd_err,
    output logic              timed_warn
);
    logic [CNT_W-1:0]  stage_count;
    logic [DATA_W-1:0] stage_pkt;
    logic [CODE_W-1:0] code;

    // Command code with the timed flag dropped.
    always_comb code = wr_data[CODE_W-1:0];

    // Staging registers, command decode and launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_count <= '0;
            stage_pkt   <= '0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            cmd_err     <= 1'b0;
            timed_warn  <= 1'b0;
            cont_flag   <= 1'b1;
            total_count <= '0;
            pkt_words   <= '0;
        end else begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            cmd_err     <= 1'b0;
            timed_warn  <= 1'b0;
            if (wr_stb) begin
                if (wr_off == OFF_W'(OFF_PKT)) begin
                    stage_pkt <= wr_data;
                end else if (wr_off == OFF_W'(OFF_CNT_LO)) begin
                    stage_count[DATA_W-1:0] <= wr_data;
                end else if (wr_off == OFF_W'(OFF_CNT_HI)) begin
                    stage_count[CNT_W-1:DATA_W] <= wr_data;
                end else if (wr_off == OFF_W'(OFF_CMD)) begin
                    timed_warn <= wr_data[DATA_W-1];
                    if (code == CODE_W'(CODE_STOP)) begin
                        stop_pulse <= 1'b1;
                    end else if (code == CODE_W'(CODE_FINITE) ||
                                 code == CODE_W'(CODE_CONT)) begin
                        start_pulse <= 1'b1;
                        cont_flag   <= (code == CODE_W'(CODE_CONT));
                        total_count <= stage_count;
                        pkt_words   <= stage_pkt;
                        stage_count <= '0;
                        stage_pkt   <= '0;
                    end else begin
                        cmd_err <= 1'b1;
                    end
                end
            end
        end
    end

    AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_pulse && stop_pulse)); // R4
    AST_ERR_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!start_pulse && !stop_pulse)); // R6
    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(wr_stb)); // R11
    AST_LAUNCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !start_pulse |-> ($stable(total_count) && $stable(pkt_words) && $stable(cont_flag))); // R4
    AST_STAGE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (stage_count == '0 && stage_pkt == '0)); // R10
    AST_TIMED_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        timed_warn |-> (start_pulse || stop_pulse || cmd_err)); // R5
endmodule

// File: rtl/radio_cmd_regs.sv
// Radio capture command register unit. Decodes writes into the radio
// window, forwards channel-0 writes to the stream configuration, flags
// writes to other channels, holds a scratch word and serves reads.
// Assumes DATA_W >= 32 so the width word fits.
module radio_cmd_regs
    import radio_cmd_pkg::*;
#(
    parameter int ADDR_W            = 20,
    parameter int DATA_W            = 32,
    parameter int BASE_ADDR         = 'h1000,
    parameter int SLOT_BYTES        = 128,
    parameter int NUM_SLOTS         = 2,
    parameter int SAMPLES_PER_CYCLE = 1,
    parameter int SAMPLE_WIDTH      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  start_pulse,
    output logic                  stop_pulse,
    output logic                  cont_flag,
    output logic [2*DATA_W-1:0]   total_count,
    output logic [DATA_W-1:0]     pkt_words,
    output logic                  cmd_err,
    output logic                  timed_warn,
    output logic                  chan_warn
);
    localparam int OFF_W  = $clog2(SLOT_BYTES);
    localparam int CHAN_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic              w_hit, r_hit;
    logic [CHAN_W-1:0] w_chan, r_chan;
    logic [OFF_W-1:0]  w_off, r_off;
    logic              ch0_stb, scr_stb, other_stb;
    logic [DATA_W-1:0] scratch;

    radio_slot_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .SLOT_BYTES(SLOT_BYTES), .NUM_SLOTS(NUM_SLOTS)) u_wdec (
        .addr(wr_addr), .hit(w_hit), .chan(w_chan), .off(w_off));

    radio_slot_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
        .SLOT_BYTES(SLOT_BYTES), .NUM_SLOTS(NUM_SLOTS)) u_rdec (
        .addr(rd_addr), .hit(r_hit), .chan(r_chan), .off(r_off));

    // Classify the write: scratch, channel 0 or unsupported channel.
    always_comb begin
        scr_stb   = wr_en && w_hit && (w_off == OFF_W'(OFF_SCRATCH));
        ch0_stb   = wr_en && w_hit && !scr_stb && (w_chan == '0);
        other_stb = wr_en && w_hit && !scr_stb && (w_chan != '0);
    end

    // Scratch word and channel warning pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scratch   <= '0;
            chan_warn <= 1'b0;
        end else begin
            chan_warn <= other_stb;
            if (scr_stb) scratch <= wr_data;
        end
    end

    // Read mux: width word, scratch aliases, zero elsewhere.
    always_comb begin
        rd_data = '0;
        if (r_hit && r_chan == '0 && r_off == OFF_W'(OFF_WIDTH)) begin
            rd_data[15:0]  = 16'(SAMPLES_PER_CYCLE);
            rd_data[31:16] = 16'(SAMPLE_WIDTH);
        end else if (r_hit && (r_off == OFF_W'(OFF_SCRATCH) ||
                               r_off == OFF_W'(OFF_SCR_ALT))) begin
            rd_data = scratch;
        end
    end

    radio_stream_cfg #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_stb(ch0_stb), .wr_off(w_off),
        .wr_data(wr_data), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
        .cont_flag(cont_flag), .total_count(total_count), .pkt_words(pkt_words),
        .cmd_err(cmd_err), .timed_warn(timed_warn));

    AST_CHAN_WARN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_warn |-> (!start_pulse && !stop_pulse && !cmd_err)); // R7
    AST_CHAN_WARN_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_warn |-> $past(wr_en)); // R11
    AST_ONE_HOT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, stop_pulse, cmd_err, chan_warn})); // R4
endmodule

// File: tb/sim_radio_cmd_regs.sv
// Bench: a vector table of writes with expected outputs, then directed
// checks for reset, reads, scratch aliases and pulse width.
module sim_radio_cmd_regs;
    typedef struct packed {
        logic [19:0] addr;
        logic [31:0] data;
        logic        st, sp, cf, er, tw, cw;
        logic [63:0] cnt;
        logic [31:0] pkt;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{20'h01028, 32'h0000_0100, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R2 stage pkt
        '{20'h01018, 32'h0000_0500, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R3 low
        '{20'h0101C, 32'h0000_0002, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R3 high
        '{20'h01018, 32'h0000_0600, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R3 low again
        '{20'h01014, 32'h0000_0001, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 64'h2_0000_0600, 32'h100},// R4 finite
        '{20'h01014, 32'h0000_0002, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R10 cleared
        '{20'h0101C, 32'h0000_0007, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h0},            // R3
        '{20'h01094, 32'h0000_0001, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 64'h0, 32'h0},            // R7 ch1 cmd
        '{20'h01098, 32'h0000_0055, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 64'h0, 32'h0},            // R7 ch1 low
        '{20'h01014, 32'h8000_0001, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 64'h7_0000_0000, 32'h0},  // R5 timed finite
        '{20'h01014, 32'h0000_0000, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 64'h7_0000_0000, 32'h0},  // R4 stop
        '{20'h01014, 32'h8000_0000, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 64'h7_0000_0000, 32'h0},  // R5 timed stop
        '{20'h01014, 32'h0000_0003, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 64'h7_0000_0000, 32'h0},  // R6 bad code
        '{20'h01014, 32'h8000_0005, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b0, 64'h7_0000_0000, 32'h0},  // R6 bad timed
        '{20'h01028, 32'h0000_0040, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 64'h7_0000_0000, 32'h0},  // R2
        '{20'h01014, 32'h0000_0002, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h40},           // R4 continuous
        '{20'h02014, 32'h0000_0001, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 64'h0, 32'h40}            // R1 outside window
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        start_pulse, stop_pulse, cont_flag, cmd_err, timed_warn, chan_warn;
    logic [63:0] total_count;
    logic [31:0] pkt_words;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    radio_cmd_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .cont_flag(cont_flag),
        .total_count(total_count), .pkt_words(pkt_words), .cmd_err(cmd_err),
        .timed_warn(timed_warn), .chan_warn(chan_warn));

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [19:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        check("R12 reset outputs",
              128'({start_pulse, stop_pulse, cont_flag, cmd_err, timed_warn, chan_warn, total_count, pkt_words}),
              128'({6'b001000, 64'h0, 32'h0}));
        rd_addr = 20'h01040; #1;
        check("R12 scratch reset", 128'(rd_data), 128'(32'h0));

        for (int i = 0; i < NV; i++) begin
            do_write(TBL[i].addr, TBL[i].data);
            check($sformatf("vec %0d (R1/R2/R3/R4/R5/R6/R7/R10)", i),
                  128'({start_pulse, stop_pulse, cont_flag, cmd_err, timed_warn, chan_warn, total_count, pkt_words}),
                  128'({TBL[i].st, TBL[i].sp, TBL[i].cf, TBL[i].er, TBL[i].tw, TBL[i].cw, TBL[i].cnt, TBL[i].pkt}));
        end

        // R11 pulses drop after one cycle
        do_write(20'h01014, 32'h8000_0002);
        @(negedge clk);
        check("R11 single cycle", 128'({start_pulse, stop_pulse, cmd_err, timed_warn, chan_warn}), 128'(5'b0));
        do_write(20'h010A0, 32'h1);
        @(negedge clk);
        check("R11 chan_warn single cycle", 128'(chan_warn), 128'(1'b0));

        // R8 width word
        rd_addr = 20'h01004; #1;
        check("R8 width word", 128'(rd_data), 128'(32'h0020_0001));
        rd_addr = 20'h01000; #1;
        check("R9 unmapped read", 128'(rd_data), 128'(32'h0));

        // R9 scratch via channel-1 alias, read at every alias
        do_write(20'h010C0, 32'hCAFE_1234);
        check("R9 scratch write no warn", 128'(chan_warn), 128'(1'b0));
        rd_addr = 20'h01040; #1;
        check("R9 read 0x1040", 128'(rd_data), 128'(32'hCAFE_1234));
        rd_addr = 20'h0103C; #1;
        check("R9 read 0x103C", 128'(rd_data), 128'(32'hCAFE_1234));
        rd_addr = 20'h010BC; #1;
        check("R9 read 0x10BC", 128'(rd_data), 128'(32'hCAFE_1234));
        do_write(20'h01040, 32'h0000_BEEF);
        rd_addr = 20'h010C0; #1;
        check("R9 read 0x10C0", 128'(rd_data), 128'(32'h0000_BEEF));

        // R1 outside window does not touch scratch
        do_write(20'h02040, 32'h1111_1111);
        rd_addr = 20'h01040; #1;
        check("R1 outside write ignored", 128'(rd_data), 128'(32'h0000_BEEF));

        done = 1'b1;
        finish_run();
    end
endmodule